// File: doc/BRIEF.md
# Row-Column 8x8 Integer Transform Engine

This block computes the two-dimensional integer cosine-type transform of an 8x8 block of signed residual samples. One 8-point 1-D transform unit is shared by both passes. In the first pass the eight rows of the block arrive one per handshake. Each row is transformed, rounded down in width and stored as a row of a 64-entry corner-turn store. In the second pass the store is read one column at a time. Each column goes through the same 1-D unit and is rounded again, and the result leaves on a valid/ready output.

A controller is pulsed to begin a block and pulses a completion flag after the eighth column has been taken. A block takes eight row cycles, then eight column cycles, then one completion cycle, plus any stall cycles added by either side. The scaling between the passes keeps the stored intermediate at a fixed width, so 8-bit inputs of any sign and amplitude come out as 16-bit coefficients without wrapping.

Top module: `dct2d_8x8`

## Requirements
- R1: While reset is held and in the cycle after it is released, `row_ready`, `col_valid` and `done` are low.
- R2: A `start` pulse while idle opens a block. From the next cycle `row_ready` stays high until eight rows have been taken with `row_valid` high. `row_ready` is never high together with `col_valid`.
- R3: Pixel j of a row (j = 0..7, left to right) is an 8-bit two's-complement value at `row_data[8j+7:8j]`. Coefficient v of an output column (vertical frequency v = 0..7) is a 16-bit two's-complement value at `col_data[16v+15:16v]`.
- R4: First pass: for each row r, intermediate Z[r][u] = (sum over j of C[u][j]·X[r][j] + 2) >>> 2. Here C is the 8x8 integer kernel. Row 0 is all 64. Row 4 is 64,-64,-64,64,64,-64,-64,64. Rows 2 and 6 start 83,36,-36,-83 and 36,-83,83,-36, and their second half mirrors the first. Rows 1,3,5,7 start 89,75,50,18 / 75,-18,-89,-50 / 50,-89,18,75 / 18,-50,75,-89, and their second half is the mirror negated.
- R5: Second pass: the columns leave in order u = 0..7, and Y[v][u] = (sum over r of C[v][r]·Z[r][u] + 256) >>> 9.
- R6: `col_valid` rises in the cycle after the eighth row is taken. While `col_ready` is low, `col_valid` stays high and `col_data` holds its value.
- R7: `done` is high for exactly one cycle, the cycle after the eighth column is taken. After it the block is idle again.
- R8: A `start` pulse while a block is in progress, including the completion cycle, has no effect. Rows offered with `row_valid` while idle are not taken.
- R9: A block of all -128 gives a DC coefficient of -16384, and a block of all 127 gives 16256. Every other coefficient of these blocks is 0, with no wrap in either pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Opens a block when idle |
| done | output | 1 | One-cycle pulse after the last column |
| row_valid | input | 1 | A row is offered on row_data |
| row_ready | output | 1 | Row pass is accepting rows |
| row_data | input | 64 | Eight signed 8-bit pixels |
| col_valid | output | 1 | A coefficient column is offered |
| col_ready | input | 1 | Consumer takes the column |
| col_data | output | 128 | Eight signed 16-bit coefficients |

## Verification
The bench goes after block contents that expose specific faults. A single off-centre impulse catches a swapped pixel or coefficient lane, or a missing transpose, because the energy would land in the wrong column or row. Full-scale positive and negative blocks catch a missing or wrongly signed rounding offset, and a first-pass shift too small to fit 16 bits, because the DC value would wrap or miss by one. A stalled consumer, gaps between rows, rows offered while idle, and start pulses during both passes catch a controller that counts ungated cycles, drops held data, or restarts in the middle of a block. Such a controller would produce shifted or duplicated columns, or a misplaced done pulse.

// File: rtl/dct2d_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the 8x8 two-pass transform.
// Assumes the transform length is fixed at 8 (the kernel is 8-point).
package dct2d_pkg;

    localparam int N_PTS = 8;

    // Odd-half kernel: entry [k][j] weights difference j for output 2k+1.
    localparam int ODD_TAB [4][4] = '{
        '{89,  75,  50,  18},
        '{75, -18, -89, -50},
        '{50, -89,  18,  75},
        '{18, -50,  75, -89}
    };

    // Sequencer phases of one block.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROWS = 2'd1,
        PH_COLS = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

endpackage

// File: rtl/dct_even4.sv
`timescale 1ns/1ps
// Even half of the 8-point transform: 4-point transform of the folded sums.
// Input lane k carries x[k]+x[7-k]; output lane k carries y[2k].
// Assumes W is wide enough to hold 512x the input magnitude.
module dct_even4 #(
    parameter int W = 26
) (
    input  logic [4*W-1:0] e_flat,
    output logic [4*W-1:0] y_flat
);
    localparam logic signed [W-1:0] K64 = W'(64);
    localparam logic signed [W-1:0] K83 = W'(83);
    localparam logic signed [W-1:0] K36 = W'(36);

    logic signed [W-1:0] e [4];
    logic signed [W-1:0] ss0, ss1, sd0, sd1;

    for (genvar k = 0; k < 4; k++) begin : g_unpack
        assign e[k] = e_flat[k*W +: W];
    end

    // Second fold of the even half.
    always_comb begin
        ss0 = e[0] + e[3];
        ss1 = e[1] + e[2];
        sd0 = e[0] - e[3];
        sd1 = e[1] - e[2];
    end

    // Weighted outputs for y0, y2, y4, y6.
    always_comb begin
        y_flat[0*W +: W] = K64 * (ss0 + ss1);
        y_flat[1*W +: W] = K83 * sd0 + K36 * sd1;
        y_flat[2*W +: W] = K64 * (ss0 - ss1);
        y_flat[3*W +: W] = K36 * sd0 - K83 * sd1;
    end
endmodule

// File: rtl/dct_odd4.sv
`timescale 1ns/1ps
// Odd half of the 8-point transform.
// Input lane j carries x[j]-x[7-j]; output lane k carries y[2k+1].
// Assumes W is wide enough to hold 512x the input magnitude.
module dct_odd4 #(
    parameter int W = 26
) (
    input  logic [4*W-1:0] o_flat,
    output logic [4*W-1:0] y_flat
);
    import dct2d_pkg::*;

    logic signed [W-1:0] o [4];

    for (genvar j = 0; j < 4; j++) begin : g_unpack
        assign o[j] = o_flat[j*W +: W];
    end

    for (genvar k = 0; k < 4; k++) begin : g_out
        logic signed [W-1:0] acc;
        // Constant-weight dot product for one odd output.
        always_comb begin
            acc = '0;
            for (int j = 0; j < 4; j++) begin
                acc = acc + W'(ODD_TAB[k][j]) * o[j];
            end
        end
        assign y_flat[k*W +: W] = acc;
    end
endmodule

// File: rtl/dct_1d8.sv
`timescale 1ns/1ps
// 8-point 1-D integer transform, full precision, purely combinational.
// Lane k of x_flat is sample k; lane k of y_flat is frequency k.
// Assumes inputs are already sign-extended to W bits.
module dct_1d8 #(
    parameter int W = 26
) (
    input  logic [8*W-1:0] x_flat,
    output logic [8*W-1:0] y_flat
);
    logic signed [W-1:0] x [8];
    logic [4*W-1:0] sum_flat, dif_flat, ev_flat, od_flat;

    for (genvar k = 0; k < 8; k++) begin : g_unpack
        assign x[k] = x_flat[k*W +: W];
    end

    for (genvar k = 0; k < 4; k++) begin : g_fold
        assign sum_flat[k*W +: W] = x[k] + x[7-k];
        assign dif_flat[k*W +: W] = x[k] - x[7-k];
    end

    dct_even4 #(.W(W)) i_even (.e_flat(sum_flat), .y_flat(ev_flat));
    dct_odd4  #(.W(W)) i_odd  (.o_flat(dif_flat), .y_flat(od_flat));

    for (genvar k = 0; k < 4; k++) begin : g_merge
        assign y_flat[(2*k)*W   +: W] = ev_flat[k*W +: W];
        assign y_flat[(2*k+1)*W +: W] = od_flat[k*W +: W];
    end
endmodule

// File: rtl/tpose_store.sv
`timescale 1ns/1ps
// Corner-turn store: N x N words, one full row written per cycle,
// one full column read per cycle (combinational read).
// Assumes the controller never reads a column before all rows are written.
module tpose_store #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_row,
    input  logic [N*W-1:0]       wr_data,
    input  logic [$clog2(N)-1:0] rd_col,
    output logic [N*W-1:0]       rd_data
);
    logic [W-1:0] mem [N][N];

    // Row write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int c = 0; c < N; c++) begin
                mem[wr_row][c] <= wr_data[c*W +: W];
            end
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_rd
        assign rd_data[r*W +: W] = mem[r][rd_col];
    end
endmodule

// File: rtl/dct2d_seq.sv
`timescale 1ns/1ps
// Block sequencer: idle -> N row handshakes -> N column handshakes -> done.
// The lane index doubles as store row (write) and store column (read).
// Assumes N is a power of two so the index wraps to zero by itself.
module dct2d_seq #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 row_valid,
    input  logic                 col_ready,
    output logic                 row_ready,
    output logic                 col_valid,
    output logic                 done,
    output logic                 row_fire,
    output logic                 col_phase,
    output logic [$clog2(N)-1:0] idx
);
    import dct2d_pkg::*;

    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    phase_e phase;

    // Phase and index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_ROWS;
                    idx   <= '0;
                end
                PH_ROWS: if (row_valid) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) phase <= PH_COLS;
                end
                PH_COLS: if (col_ready) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) phase <= PH_FIN;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the phase.
    always_comb begin
        row_ready = (phase == PH_ROWS);
        col_valid = (phase == PH_COLS);
        done      = (phase == PH_FIN);
        col_phase = col_valid;
        row_fire  = row_ready && row_valid;
    end
endmodule

// File: rtl/dct2d_8x8.sv
`timescale 1ns/1ps
// Two-pass 8x8 integer transform with one shared 1-D unit.
// Rows are transformed, rounded by SH_ROW and stored; columns are read back,
// transformed and rounded by SH_COL. Assumes BUF_W >= PIX_W.
module dct2d_8x8 #(
    parameter int PIX_W  = 8,
    parameter int BUF_W  = 16,
    parameter int OUT_W  = 16,
    parameter int SH_ROW = 2,
    parameter int SH_COL = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    output logic                            done,
    input  logic                            row_valid,
    output logic                            row_ready,
    input  logic [dct2d_pkg::N_PTS*PIX_W-1:0] row_data,
    output logic                            col_valid,
    input  logic                            col_ready,
    output logic [dct2d_pkg::N_PTS*OUT_W-1:0] col_data
);
    import dct2d_pkg::*;

    localparam int N      = N_PTS;
    localparam int IW     = $clog2(N);
    localparam int ACC_W  = BUF_W + 10;
    localparam int RND_RW = 1 << (SH_ROW - 1);
    localparam int RND_CL = 1 << (SH_COL - 1);

    logic            row_fire, col_phase;
    logic [IW-1:0]   idx;
    logic [N*ACC_W-1:0] unit_in, unit_out;
    logic [N*BUF_W-1:0] stage_wr, stage_rd;

    dct2d_seq #(.N(N)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .row_valid(row_valid), .col_ready(col_ready),
        .row_ready(row_ready), .col_valid(col_valid), .done(done),
        .row_fire(row_fire), .col_phase(col_phase), .idx(idx)
    );

    // Per-lane input select, sign extension and rounding of both passes.
    for (genvar k = 0; k < N; k++) begin : g_lane
        logic signed [ACC_W-1:0] yk;
        assign unit_in[k*ACC_W +: ACC_W] = col_phase
            ? ACC_W'($signed(stage_rd[k*BUF_W +: BUF_W]))
            : ACC_W'($signed(row_data[k*PIX_W +: PIX_W]));
        assign yk = unit_out[k*ACC_W +: ACC_W];
        assign stage_wr[k*BUF_W +: BUF_W] = BUF_W'((yk + ACC_W'(RND_RW)) >>> SH_ROW);
        assign col_data[k*OUT_W +: OUT_W] = OUT_W'((yk + ACC_W'(RND_CL)) >>> SH_COL);
    end

    dct_1d8 #(.W(ACC_W)) i_unit (.x_flat(unit_in), .y_flat(unit_out));

    tpose_store #(.N(N), .W(BUF_W)) i_store (
        .clk(clk), .wr_en(row_fire), .wr_row(idx), .wr_data(stage_wr),
        .rd_col(idx), .rd_data(stage_rd)
    );
endmodule

// File: rtl/dct2d_8x8_chk.sv
`timescale 1ns/1ps
// Protocol checker for dct2d_8x8, attached by bind below.
module dct2d_8x8_chk #(
    parameter int CW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          row_valid,
    input logic          row_ready,
    input logic          col_valid,
    input logic          col_ready,
    input logic [CW-1:0] col_data
);
    logic [3:0] rows_seen;

    // Counts rows taken in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || done) rows_seen <= '0;
        else if (row_valid && row_ready) rows_seen <= rows_seen + 4'd1;
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_ready && col_valid)); // R2
    AST_ROW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid) |-> rows_seen == 4'd8); // R2
    AST_COL_AFTER_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_ready && rows_seen == 4'd7) |=> col_valid); // R6
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_ready) |=> (col_valid && $stable(col_data))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(col_valid && col_ready)); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && start) |=> !row_ready); // R8
endmodule

bind dct2d_8x8 dct2d_8x8_chk #(.CW(dct2d_pkg::N_PTS*OUT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .row_valid(row_valid), .row_ready(row_ready),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data)
);

// File: tb/test_dct2d_8x8.sv
`timescale 1ns/1ps
// Directed bench for dct2d_8x8 with a direct matrix-product reference.
module test_dct2d_8x8;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         done;
    logic         row_valid = 1'b0;
    logic         row_ready;
    logic [63:0]  row_data = '0;
    logic         col_valid;
    logic         col_ready = 1'b0;
    logic [127:0] col_data;

    int  vectors = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    int  blk [8][8];
    int  exp_y [8][8];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dct2d_8x8 i_dct2d_8x8 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .row_valid(row_valid), .row_ready(row_ready), .row_data(row_data),
        .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data)
    );

    // Kernel entry C[k][n] written out from the requirement R4.
    function automatic int kc(int k, int n);
        int t [8];
        case (k)
            0: t = '{64, 64, 64, 64, 64, 64, 64, 64};
            1: t = '{89, 75, 50, 18, -18, -50, -75, -89};
            2: t = '{83, 36, -36, -83, -83, -36, 36, 83};
            3: t = '{75, -18, -89, -50, 50, 89, 18, -75};
            4: t = '{64, -64, -64, 64, 64, -64, -64, 64};
            5: t = '{50, -89, 18, 75, -75, -18, 89, -50};
            6: t = '{36, -83, 83, -36, -36, 83, -83, 36};
            default: t = '{18, -50, 75, -89, 89, -75, 50, -18};
        endcase
        return t[n];
    endfunction

    function automatic int rshift(int a, int s);
        return (a + (1 << (s - 1))) >>> s;
    endfunction

    // Reference per R4 and R5.
    task automatic compute_ref();
        int z [8][8];
        for (int r = 0; r < 8; r++)
            for (int u = 0; u < 8; u++) begin
                int acc = 0;
                for (int j = 0; j < 8; j++) acc += kc(u, j) * blk[r][j];
                z[r][u] = rshift(acc, 2);
            end
        for (int v = 0; v < 8; v++)
            for (int u = 0; u < 8; u++) begin
                int acc = 0;
                for (int r = 0; r < 8; r++) acc += kc(v, r) * z[r][u];
                exp_y[v][u] = rshift(acc, 9);
            end
    endtask

    task automatic check(input string req, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [63:0] pack_row(int r);
        logic [63:0] d = '0;
        for (int j = 0; j < 8; j++) d[j*8 +: 8] = 8'(blk[r][j]);
        return d;
    endfunction

    function automatic int next_pix();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]) - 128;
    endfunction

    // Drives one block and checks every coefficient (R3, R5, R6, R7, R8).
    task automatic run_block(input int stall, input bit gaps, input bit poke_rows,
                             input bit poke_cols, input string tag);
        compute_ref();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R2 row_ready open ", tag}, int'(row_ready), 1);
        for (int r = 0; r < 8; r++) begin
            if (gaps) begin
                row_valid = 1'b0;
                @(negedge clk);
            end
            row_valid = 1'b1;
            row_data  = pack_row(r);
            if (poke_rows && r == 3) start = 1'b1;
            check({"R2 row_ready in row pass ", tag}, int'(row_ready), 1);
            check({"R2 col_valid low in row pass ", tag}, int'(col_valid), 0);
            @(negedge clk);
            start = 1'b0;
        end
        row_valid = 1'b0;
        row_data  = '0;
        check({"R6 col_valid after rows ", tag}, int'(col_valid), 1);
        check({"R2 row_ready closed ", tag}, int'(row_ready), 0);
        for (int u = 0; u < 8; u++) begin
            for (int s = 0; s < stall; s++) begin
                logic [127:0] held = col_data;
                col_ready = 1'b0;
                @(negedge clk);
                check({"R6 col_valid held ", tag}, int'(col_valid), 1);
                check({"R6 col_data held ", tag}, int'(col_data == held), 1);
            end
            col_ready = 1'b1;
            if (poke_cols && u == 2) start = 1'b1;
            check({"R7 done low in column pass ", tag}, int'(done), 0);
            for (int v = 0; v < 8; v++)
                check({"R5 coefficient ", tag}, int'($signed(col_data[v*16 +: 16])), exp_y[v][u]);
            @(negedge clk);
            start = 1'b0;
            col_ready = 1'b0;
        end
        check({"R7 done pulse ", tag}, int'(done), 1);
        check({"R7 col_valid off ", tag}, int'(col_valid), 0);
        @(negedge clk);
        check({"R7 done single cycle ", tag}, int'(done), 0);
        check({"R8 idle after block ", tag}, int'(row_ready), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 row_ready", int'(row_ready), 0);
        check("R1 col_valid", int'(col_valid), 0);
        check("R1 done", int'(done), 0);
    endtask

    task automatic t_zero();
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = 0;
        run_block(0, 1'b0, 1'b0, 1'b0, "R5 zero block");
    endtask

    task automatic t_max_neg();
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = -128;
        compute_ref();
        check("R9 reference DC -128", exp_y[0][0], -16384);
        run_block(0, 1'b0, 1'b0, 1'b0, "R9 all -128");
    endtask

    task automatic t_max_pos();
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = 127;
        compute_ref();
        check("R9 reference DC 127", exp_y[0][0], 16256);
        run_block(0, 1'b0, 1'b0, 1'b0, "R9 all 127");
    endtask

    task automatic t_impulse();
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = 0;
        blk[2][5] = 100;
        run_block(0, 1'b0, 1'b0, 1'b0, "R3 impulse at row 2 col 5");
    endtask

    task automatic t_checker();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) blk[r][c] = ((r + c) % 2 != 0) ? 127 : -128;
        run_block(0, 1'b0, 1'b0, 1'b0, "R4 checkerboard");
    endtask

    task automatic t_ramp();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) blk[r][c] = r * 16 + c * 2 - 128;
        run_block(0, 1'b0, 1'b0, 1'b0, "R4 ramp");
    endtask

    task automatic t_random();
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = next_pix();
            run_block(0, 1'b0, 1'b0, 1'b0, "R5 random");
        end
    endtask

    task automatic t_backpressure();
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = next_pix();
        run_block(2, 1'b1, 1'b0, 1'b0, "R6 stalls and row gaps");
    endtask

    task automatic t_start_busy();
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = next_pix();
        run_block(1, 1'b0, 1'b1, 1'b1, "R8 start while busy");
    endtask

    task automatic t_idle_rows();
        row_valid = 1'b1;
        row_data  = 64'h7F7F_7F7F_7F7F_7F7F;
        for (int i = 0; i < 3; i++) begin
            check("R8 row_ready low while idle", int'(row_ready), 0);
            @(negedge clk);
        end
        row_valid = 1'b0;
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) blk[r][c] = next_pix();
        run_block(0, 1'b0, 1'b0, 1'b0, "R8 idle rows ignored");
    endtask

    initial begin
        t_reset();
        t_zero();
        t_max_neg();
        t_max_pos();
        t_impulse();
        t_checker();
        t_ramp();
        t_random();
        t_backpressure();
        t_start_busy();
        t_idle_rows();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule